// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block walks a 32-bit core through the entry of an external interrupt. When a request with a vector number arrives and the core's interrupt-enable flag is set, it takes a snapshot of the core state it needs. It then steps through a fixed order of register updates and drives them onto write-strobe outputs that the core's register file applies. The order is: leave user mode, push the status register, swap stacks if the core was in user mode, save the return address, and record the exception cause.

It then reads the handler address from a vector table in memory. The read goes over a request/acknowledge port at the exception base plus four times the vector. The word that is returned is loaded into the PC, and a one-cycle done pulse marks the end. If the table read reports an error, the sequence stops without touching the PC and raises a one-cycle error pulse. A sequence cannot be interrupted, and requests that arrive while one is running are not taken.

Top module: `irq_entry_seq`

## Requirements
- R1: When `core_ie` is 0, a request is ignored: `busy` stays 0 and no write strobe, `ubit_clr` or `mem_req` is raised.
- R2: The pushed status value on `ccs_wdata` is the old status shifted left by 10 with bits 31:30 cleared, and then bit 31 set to the old bit 31. Bit 30 is therefore always 0.
- R3: In the first cycle after a request is accepted, only `ubit_clr` is high. All other register strobes come later.
- R4: In the cycle after `ubit_clr`, if the core was in user mode (`core_user`=1 at acceptance), `usp_we` writes the old SP and `sp_we` writes the kernel SP. In kernel mode neither strobe is raised.
- R5: In the same cycle as `ccs_we`, `erp_we` writes the PC captured at acceptance, `exs_we` writes the vector times 256 and `eda_clr` is high.
- R6: In the cycle after the status push, `mem_req` rises with `mem_addr` = base + vector×4. Both are held stable until the first cycle in which `mem_ack` is sampled high. `mem_rdata[7:0]` holds the lowest-addressed byte (little-endian), and the word is used unmodified.
- R7: If the acknowledged read has `mem_err`=0, then in the next cycle `pc_we` and `done` are high for one cycle and `pc_wdata` equals the read word.
- R8: If the acknowledged read has `mem_err`=1, then in the next cycle `err` is high for one cycle and `pc_we` stays 0.
- R9: `busy` is high from the cycle after acceptance through the final cycle of the sequence. A request held high during a sequence does not start a second one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request level |
| irq_vec | input | 8 | Vector number of the request |
| core_ie | input | 1 | Interrupt-enable flag of the core |
| core_user | input | 1 | Core is in user mode |
| core_ccs | input | 32 | Current status register |
| core_pc | input | 32 | Current PC (return address) |
| core_sp | input | 32 | Current stack pointer |
| core_ksp | input | 32 | Kernel stack pointer |
| core_ebp | input | 32 | Exception vector table base |
| busy | output | 1 | Sequence in progress |
| ubit_clr | output | 1 | Clear the user-mode bit |
| ccs_we | output | 1 | Write status register |
| ccs_wdata | output | 32 | Pushed status value |
| usp_we | output | 1 | Write user SP register |
| usp_wdata | output | 32 | Saved user SP |
| sp_we | output | 1 | Write stack pointer |
| sp_wdata | output | 32 | Kernel SP to load |
| erp_we | output | 1 | Write exception return register |
| erp_wdata | output | 32 | Return PC |
| exs_we | output | 1 | Write exception status register |
| exs_wdata | output | 32 | Vector times 256 |
| eda_clr | output | 1 | Clear exception data-address register |
| mem_req | output | 1 | Vector table read request |
| mem_addr | output | 32 | Vector table entry address |
| mem_ack | input | 1 | Read acknowledge |
| mem_err | input | 1 | Read failed (valid with ack) |
| mem_rdata | input | 32 | Read data, little-endian word |
| pc_we | output | 1 | Load PC |
| pc_wdata | output | 32 | Handler address |
| done | output | 1 | Sequence completed |
| err | output | 1 | Sequence aborted on read error |

## Verification
A wrong internal state in this sequencer shows up at the strobes within one to three cycles of acceptance. A stuck or skipped step either drops a strobe or moves it into the wrong cycle, so every cycle of every sequence is compared against its expected set of strobes. A corrupted snapshot or vector latch shows up as a wrong data word in the save cycle, or as a wrong table address as soon as `mem_req` rises. A fault on the acknowledge path shows up one cycle after the handshake: either the PC is loaded on an error, or `done` or `busy` is held past the end of the sequence.

// File: rtl/irq_seq_pkg.sv
// Shared types for the interrupt entry sequencer.
package irq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KERN,
        ST_SAVE,
        ST_FETCH,
        ST_LOAD,
        ST_FAIL
    } seq_state_t;
endpackage

// File: rtl/irq_status_push.sv
// Computes the pushed status word: old value shifted left, the two top
// bits cleared, then the old top bit restored. Pure combinational.
// Assumes SHIFT < XLEN - 1.
module irq_status_push #(
    parameter int XLEN  = 32,
    parameter int SHIFT = 10
) (
    input  logic [XLEN-1:0] old_val,
    output logic [XLEN-1:0] new_val
);
    localparam logic [XLEN-1:0] LOW_MASK = {2'b00, {(XLEN-2){1'b1}}};

    // shift, mask, keep top bit
    always_comb begin
        new_val = ((old_val << SHIFT) & LOW_MASK) | {old_val[XLEN-1], {(XLEN-1){1'b0}}};
    end
endmodule

// File: rtl/irq_vec_calc.sv
// Derives the cause word and the vector table entry address from the
// vector number. Pure combinational; addition wraps at XLEN bits.
module irq_vec_calc #(
    parameter int XLEN        = 32,
    parameter int VEC_W       = 8,
    parameter int CAUSE_SHIFT = 8,
    parameter int ENTRY_SHIFT = 2
) (
    input  logic [VEC_W-1:0] vec,
    input  logic [XLEN-1:0]  base,
    output logic [XLEN-1:0]  cause,
    output logic [XLEN-1:0]  entry_addr
);
    localparam int PAD_W = XLEN - VEC_W;

    logic [XLEN-1:0] vec_ext;

    // widen vector, scale for cause and table offset
    always_comb begin
        vec_ext    = {{PAD_W{1'b0}}, vec};
        cause      = vec_ext << CAUSE_SHIFT;
        entry_addr = base + (vec_ext << ENTRY_SHIFT);
    end
endmodule

// File: rtl/irq_seq_fsm.sv
// Step controller: idle -> leave user mode -> save registers -> table
// read -> load PC or fail -> idle. Accepts a request only when idle
// and enabled. Assumes mem_err is meaningful only with mem_ack.
module irq_seq_fsm
    import irq_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       irq_req,
    input  logic       ie,
    input  logic       mem_ack,
    input  logic       mem_err,
    output seq_state_t state,
    output logic       accept
);
    seq_state_t nxt;

    // accept only from idle with enable set
    always_comb accept = (state == ST_IDLE) && irq_req && ie;

    // next-state selection
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (accept) nxt = ST_KERN;
            ST_KERN:  nxt = ST_SAVE;
            ST_SAVE:  nxt = ST_FETCH;
            ST_FETCH: if (mem_ack) nxt = mem_err ? ST_FAIL : ST_LOAD;
            ST_LOAD:  nxt = ST_IDLE;
            ST_FAIL:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // state register, synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end
endmodule

// File: rtl/irq_entry_seq.sv
// Interrupt entry sequencer top. Snapshots core state on acceptance,
// emits register write strobes in a fixed order, reads the handler
// address from the vector table and loads it into the PC.
// Assumes the core applies each strobe in the cycle it is high.
module irq_entry_seq
    import irq_seq_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int VEC_W = 8,
    parameter int SHIFT = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_req,
    input  logic [VEC_W-1:0] irq_vec,
    input  logic             core_ie,
    input  logic             core_user,
    input  logic [XLEN-1:0]  core_ccs,
    input  logic [XLEN-1:0]  core_pc,
    input  logic [XLEN-1:0]  core_sp,
    input  logic [XLEN-1:0]  core_ksp,
    input  logic [XLEN-1:0]  core_ebp,
    output logic             busy,
    output logic             ubit_clr,
    output logic             ccs_we,
    output logic [XLEN-1:0]  ccs_wdata,
    output logic             usp_we,
    output logic [XLEN-1:0]  usp_wdata,
    output logic             sp_we,
    output logic [XLEN-1:0]  sp_wdata,
    output logic             erp_we,
    output logic [XLEN-1:0]  erp_wdata,
    output logic             exs_we,
    output logic [XLEN-1:0]  exs_wdata,
    output logic             eda_clr,
    output logic             mem_req,
    output logic [XLEN-1:0]  mem_addr,
    input  logic             mem_ack,
    input  logic             mem_err,
    input  logic [XLEN-1:0]  mem_rdata,
    output logic             pc_we,
    output logic [XLEN-1:0]  pc_wdata,
    output logic             done,
    output logic             err
);
    seq_state_t       state;
    logic             accept;
    logic [VEC_W-1:0] snap_vec;
    logic             snap_user;
    logic [XLEN-1:0]  snap_ccs, snap_pc, snap_sp, snap_ksp, snap_ebp;
    logic [XLEN-1:0]  handler;

    irq_seq_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_req (irq_req),
        .ie      (core_ie),
        .mem_ack (mem_ack),
        .mem_err (mem_err),
        .state   (state),
        .accept  (accept)
    );

    irq_status_push #(.XLEN(XLEN), .SHIFT(SHIFT)) u_push (
        .old_val (snap_ccs),
        .new_val (ccs_wdata)
    );

    irq_vec_calc #(.XLEN(XLEN), .VEC_W(VEC_W)) u_vec (
        .vec        (snap_vec),
        .base       (snap_ebp),
        .cause      (exs_wdata),
        .entry_addr (mem_addr)
    );

    // capture the core view at the moment of acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            snap_vec  <= '0;
            snap_user <= 1'b0;
            snap_ccs  <= '0;
            snap_pc   <= '0;
            snap_sp   <= '0;
            snap_ksp  <= '0;
            snap_ebp  <= '0;
        end else if (accept) begin
            snap_vec  <= irq_vec;
            snap_user <= core_user;
            snap_ccs  <= core_ccs;
            snap_pc   <= core_pc;
            snap_sp   <= core_sp;
            snap_ksp  <= core_ksp;
            snap_ebp  <= core_ebp;
        end
    end

    // latch the handler word on the acknowledged read
    always_ff @(posedge clk) begin
        if (!rst_n)                            handler <= '0;
        else if (state == ST_FETCH && mem_ack) handler <= mem_rdata;
    end

    // strobe decode from the current step
    always_comb begin
        busy      = (state != ST_IDLE);
        ubit_clr  = (state == ST_KERN);
        ccs_we    = (state == ST_SAVE);
        usp_we    = (state == ST_SAVE) && snap_user;
        sp_we     = (state == ST_SAVE) && snap_user;
        erp_we    = (state == ST_SAVE);
        exs_we    = (state == ST_SAVE);
        eda_clr   = (state == ST_SAVE);
        mem_req   = (state == ST_FETCH);
        pc_we     = (state == ST_LOAD);
        done      = (state == ST_LOAD);
        err       = (state == ST_FAIL);
        usp_wdata = snap_sp;
        sp_wdata  = snap_ksp;
        erp_wdata = snap_pc;
        pc_wdata  = handler;
    end
endmodule

// File: rtl/irq_entry_chk.sv
// Protocol checker for irq_entry_seq, attached by bind.
module irq_entry_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            irq_req,
    input logic            core_ie,
    input logic            busy,
    input logic            ubit_clr,
    input logic            ccs_we,
    input logic [XLEN-1:0] ccs_wdata,
    input logic            usp_we,
    input logic            sp_we,
    input logic            pc_we,
    input logic            done,
    input logic            err,
    input logic            mem_req,
    input logic [XLEN-1:0] mem_addr,
    input logic            mem_ack,
    input logic            mem_err
);
    AST_MASKED_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && irq_req && !core_ie) |=> (!busy && !ubit_clr)); // R1
    AST_STATUS_BIT30_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ccs_we |-> (ccs_wdata[XLEN-2] == 1'b0)); // R2
    AST_KERNEL_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        ccs_we |-> $past(ubit_clr)); // R3
    AST_STACK_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (usp_we == sp_we) && (!usp_we || ccs_we)); // R4
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R6
    AST_PC_AFTER_GOOD_READ: assert property (@(posedge clk) disable iff (!rst_n)
        pc_we |-> ($past(mem_req && mem_ack && !mem_err) && done)); // R7
    AST_FAIL_NO_PC: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!pc_we && $past(mem_req && mem_ack && mem_err))); // R8
    AST_NO_REENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !ubit_clr); // R9
    AST_END_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err})); // R8
endmodule

bind irq_entry_seq irq_entry_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .irq_req   (irq_req),
    .core_ie   (core_ie),
    .busy      (busy),
    .ubit_clr  (ubit_clr),
    .ccs_we    (ccs_we),
    .ccs_wdata (ccs_wdata),
    .usp_we    (usp_we),
    .sp_we     (sp_we),
    .pc_we     (pc_we),
    .done      (done),
    .err       (err),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_ack   (mem_ack),
    .mem_err   (mem_err)
);

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic [7:0]  irq_vec = '0;
    logic        core_ie = 1'b0, core_user = 1'b0;
    logic [31:0] core_ccs = '0, core_pc = '0, core_sp = '0, core_ksp = '0, core_ebp = '0;
    logic        busy, ubit_clr, ccs_we, usp_we, sp_we, erp_we, exs_we, eda_clr;
    logic [31:0] ccs_wdata, usp_wdata, sp_wdata, erp_wdata, exs_wdata;
    logic        mem_req, mem_ack = 1'b0, mem_err = 1'b0;
    logic [31:0] mem_addr, mem_rdata = '0, pc_wdata;
    logic        pc_we, done, err;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_vec(irq_vec),
        .core_ie(core_ie), .core_user(core_user), .core_ccs(core_ccs),
        .core_pc(core_pc), .core_sp(core_sp), .core_ksp(core_ksp), .core_ebp(core_ebp),
        .busy(busy), .ubit_clr(ubit_clr), .ccs_we(ccs_we), .ccs_wdata(ccs_wdata),
        .usp_we(usp_we), .usp_wdata(usp_wdata), .sp_we(sp_we), .sp_wdata(sp_wdata),
        .erp_we(erp_we), .erp_wdata(erp_wdata), .exs_we(exs_we), .exs_wdata(exs_wdata),
        .eda_clr(eda_clr), .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
        .mem_err(mem_err), .mem_rdata(mem_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
        .done(done), .err(err)
    );

    function automatic logic [31:0] exp_status(input logic [31:0] old);
        return ((old << 10) & 32'h3FFF_FFFF) | (old & 32'h8000_0000);
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // one full accepted sequence, checked cycle by cycle at negedges
    task automatic run_seq(input logic [7:0] vec, input logic [31:0] ccs, input logic [31:0] pc,
                           input logic [31:0] sp, input logic [31:0] ksp, input logic [31:0] ebp,
                           input logic user, input int lat, input logic fail, input logic hold,
                           input logic [31:0] hword);
        @(negedge clk);
        irq_vec = vec; core_ccs = ccs; core_pc = pc; core_sp = sp; core_ksp = ksp;
        core_ebp = ebp; core_user = user; core_ie = 1'b1; irq_req = 1'b1;
        @(negedge clk);
        if (!hold) irq_req = 1'b0;
        core_pc = ~pc; core_sp = ~sp;
        chk("R3 ubit_clr first", {31'd0, ubit_clr}, 32'd1);
        chk("R3 no early writes", {26'd0, ccs_we, usp_we, sp_we, erp_we, exs_we, eda_clr}, 32'd0);
        chk("R9 busy", {31'd0, busy}, 32'd1);
        @(negedge clk);
        chk("R3 ubit_clr once", {31'd0, ubit_clr}, 32'd0);
        chk("R2 status push", ccs_wdata, exp_status(ccs));
        chk("R2 ccs_we", {31'd0, ccs_we}, 32'd1);
        chk("R4 stack strobes", {30'd0, usp_we, sp_we}, user ? 32'd3 : 32'd0);
        if (user) begin
            chk("R4 usp data", usp_wdata, sp);
            chk("R4 sp data", sp_wdata, ksp);
        end
        chk("R5 erp", {31'd0, erp_we} ^ 32'd0, 32'd1);
        chk("R5 erp data", erp_wdata, pc);
        chk("R5 exs data", exs_wdata, {24'd0, vec} * 32'd256);
        chk("R5 exs/eda strobes", {30'd0, exs_we, eda_clr}, 32'd3);
        chk("R6 no req yet", {31'd0, mem_req}, 32'd0);
        @(negedge clk);
        chk("R6 req", {31'd0, mem_req}, 32'd1);
        chk("R6 addr", mem_addr, ebp + {24'd0, vec} * 32'd4);
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R6 req held", {31'd0, mem_req}, 32'd1);
            chk("R6 addr held", mem_addr, ebp + {24'd0, vec} * 32'd4);
            chk("R7 no early pc", {31'd0, pc_we}, 32'd0);
        end
        mem_ack = 1'b1; mem_err = fail; mem_rdata = hword; irq_req = 1'b0;
        @(negedge clk);
        mem_ack = 1'b0; mem_err = 1'b0; mem_rdata = 32'hDEAD_BEEF;
        chk("R6 req dropped", {31'd0, mem_req}, 32'd0);
        if (fail) begin
            chk("R8 err", {31'd0, err}, 32'd1);
            chk("R8 no pc", {30'd0, pc_we, done}, 32'd0);
        end else begin
            chk("R7 pc_we/done", {30'd0, pc_we, done}, 32'd3);
            chk("R7 handler", pc_wdata, hword);
            chk("R7 no err", {31'd0, err}, 32'd0);
        end
        @(negedge clk);
        chk("R9 idle after", {31'd0, busy}, 32'd0);
        chk("R9 pulses end", {28'd0, pc_we, done, err, ubit_clr}, 32'd0);
    endtask

    task automatic run_masked(input logic [7:0] vec, input logic user);
        @(negedge clk);
        irq_vec = vec; core_user = user; core_ie = 1'b0; irq_req = 1'b1;
        @(negedge clk);
        chk("R1 masked busy", {31'd0, busy}, 32'd0);
        chk("R1 masked strobes", {29'd0, ubit_clr, ccs_we, mem_req}, 32'd0);
        @(negedge clk);
        irq_req = 1'b0;
        chk("R1 masked later", {28'd0, busy, ccs_we, usp_we, mem_req}, 32'd0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        int seed;
        seed = 32'h1234_5678;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset idle", {31'd0, busy}, 32'd0);
        chk("R6 reset no req", {31'd0, mem_req}, 32'd0);
        chk("R7 reset no pc", {29'd0, pc_we, done, err}, 32'd0);

        run_masked(8'h05, 1'b1);
        run_seq(8'h00, 32'hFFFF_FFFF, 32'h1000, 32'h2000, 32'h3000, 32'h4000, 1'b1, 0, 1'b0, 1'b0, 32'h0403_0201);
        run_seq(8'hFF, 32'h8000_0001, 32'h0000_0ABC, 32'h1, 32'h2, 32'hFFFF_FF00, 1'b0, 3, 1'b0, 1'b1, 32'hCAFE_F00D);
        run_seq(8'h10, 32'h7FFF_FFFF, 32'h5555_0000, 32'h10, 32'h20, 32'h0, 1'b1, 2, 1'b1, 1'b0, 32'h1111_1111);
        run_masked(8'hFF, 1'b0);
        run_seq(8'h01, 32'h0020_0000, 32'h8, 32'h9, 32'hA, 32'hB, 1'b0, 0, 1'b1, 1'b1, 32'h0);

        for (int k = 0; k < 40; k++) begin
            if ($urandom_range(0, 7) == 0)
                run_masked(8'($urandom), 1'($urandom));
            else
                run_seq(8'($urandom), $urandom, $urandom, $urandom, $urandom, $urandom,
                        1'($urandom), $urandom_range(0, 4), ($urandom_range(0, 4) == 0),
                        1'($urandom), $urandom);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule